// File: doc/BRIEF.md
# Adaptive Minimal-Path Torus Route Selector

This block picks the output port of one switch in a two-dimensional torus where every link carries traffic both ways. For each head message it takes the switch's own coordinates and the destination coordinates. In each ring dimension it works out which way around the ring is shorter, and it treats only those shorter directions as candidate ports.

When adaptive routing is enabled and both dimensions still have distance to cover, the block sends the message to the candidate whose outgoing queue is shorter. When adaptive routing is disabled, the block routes the X dimension fully and then Y. All messages between one pair of nodes then follow one path and arrive in order. A message that has reached its destination goes to the local eject output.

A recovery pulse turns adaptive routing off at once. Adaptivity comes back only after a programmable number of checkpoint intervals pass with no further recovery. A programmed count of zero leaves the switch in deterministic routing for good.

Top module: `torus_route_sel`

## Requirements
- R1: When the destination coordinates equal the current coordinates, `eject` is 1 and all four bits of `port_sel` are 0.
- R2: In every cycle out of reset, exactly one of the five signals {`port_sel[3:0]`, `eject`} is 1.
- R3: Direction choice in a dimension uses the distance d = (dst − cur) mod K. The positive port is chosen when 2·d ≤ K and the negative port otherwise, so a tie at exactly K/2 goes positive. Port encoding is: bit0 X+, bit1 X−, bit2 Y+, bit3 Y−.
- R4: With adaptive routing off, the X port is selected whenever the X coordinates differ. The Y port is used only when X already matches.
- R5: With adaptive routing on and both dimensions unfinished, the block compares the queue of the chosen X port with the queue of the chosen Y port. The port with the smaller length is selected, and equal lengths select the X port.
- R6: With adaptive routing on and only one dimension unfinished, that dimension's port is selected whatever the queue lengths are.
- R7: After reset, `adaptive_on` is 1.
- R8: A cycle with `recover` high makes `adaptive_on` 0 from the next cycle on.
- R9: While adaptivity is disabled and `reenable_cnt` = N > 0, `adaptive_on` becomes 1 in the cycle after the N-th `ckpt_tick` counted since the last recovery. A new recovery restarts the count.
- R10: While `reenable_cnt` is 0, `ckpt_tick` pulses leave `adaptive_on` at 0.
- R11: When `recover` and `ckpt_tick` are high in the same cycle, the recovery wins, and `adaptive_on` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cur_x | input | XW | X coordinate of this switch |
| cur_y | input | YW | Y coordinate of this switch |
| dst_x | input | XW | destination X coordinate |
| dst_y | input | YW | destination Y coordinate |
| q_xp | input | QW | occupancy of the X+ output queue |
| q_xn | input | QW | occupancy of the X− output queue |
| q_yp | input | QW | occupancy of the Y+ output queue |
| q_yn | input | QW | occupancy of the Y− output queue |
| recover | input | 1 | pulse marking a system recovery |
| ckpt_tick | input | 1 | pulse at each checkpoint interval boundary |
| reenable_cnt | input | CW | number of clean intervals before adaptivity returns; 0 means never |
| port_sel | output | 4 | one-hot output port: X+, X−, Y+, Y− |
| eject | output | 1 | deliver to the local node |
| adaptive_on | output | 1 | adaptive routing currently enabled |

## Verification
The bench builds the block with a ring of 5 in X and a ring of 4 in Y. The odd ring can never tie. The even ring gives an exact half-way distance, so the positive tie rule of R3 can be hit. The queue width is 3 bits, so random queue lengths often tie and the X preference of R5 gets exercised. The count width is 4 bits, so re-enable counts of 0, 1 and 3 can all be reached within a few cycles. That covers the restart-on-recovery case and the case where recovery and tick arrive together.

// File: rtl/torus_route_sel.sv
module torus_route_sel #(
  parameter int KX = 8,
  parameter int KY = 8,
  parameter int QW = 4,
  parameter int CW = 8,
  localparam int XW = (KX > 1) ? $clog2(KX) : 1,
  localparam int YW = (KY > 1) ? $clog2(KY) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [QW-1:0] q_xp,
  input  logic [QW-1:0] q_xn,
  input  logic [QW-1:0] q_yp,
  input  logic [QW-1:0] q_yn,
  input  logic          recover,
  input  logic          ckpt_tick,
  input  logic [CW-1:0] reenable_cnt,
  output logic [3:0]    port_sel,
  output logic          eject,
  output logic          adaptive_on
);

  logic          adapt_q;
  logic [CW-1:0] clean_q;
  logic          need_x, need_y, x_pos, y_pos;
  logic [QW-1:0] qx, qy;

  always_comb begin
    int ddx, ddy;
    ddx = int'(dst_x) - int'(cur_x);
    ddy = int'(dst_y) - int'(cur_y);
    if (ddx < 0) ddx = ddx + KX;
    if (ddy < 0) ddy = ddy + KY;
    need_x = (ddx != 0);
    need_y = (ddy != 0);
    x_pos  = (2 * ddx <= KX);
    y_pos  = (2 * ddy <= KY);
  end

  assign qx = x_pos ? q_xp : q_xn;
  assign qy = y_pos ? q_yp : q_yn;

  always_comb begin
    port_sel = 4'b0000;
    eject    = 1'b0;
    if (need_x && (!need_y || !adapt_q || qx <= qy))
      port_sel = x_pos ? 4'b0001 : 4'b0010;
    else if (need_y)
      port_sel = y_pos ? 4'b0100 : 4'b1000;
    else
      eject = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adapt_q <= 1'b1;
      clean_q <= '0;
    end else if (recover) begin
      adapt_q <= 1'b0;
      clean_q <= '0;
    end else if (!adapt_q && ckpt_tick && reenable_cnt != '0) begin
      if ({1'b0, clean_q} + 1'b1 >= {1'b0, reenable_cnt}) begin
        adapt_q <= 1'b1;
        clean_q <= '0;
      end else begin
        clean_q <= clean_q + 1'b1;
      end
    end
  end

  assign adaptive_on = adapt_q;

  // R2
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({port_sel, eject}) == 1);

  // R1
  eject_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eject == (cur_x == dst_x && cur_y == dst_y));

  // R4
  static_xfirst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adaptive_on && cur_x != dst_x) |-> (port_sel[0] || port_sel[1]));

  // R8
  recover_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> !adaptive_on);

  // R10
  never_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adaptive_on && reenable_cnt == '0) |=> !adaptive_on);

endmodule

// File: tb/test_torus_route_sel.sv
module test_torus_route_sel;
  localparam int CLK_P = 10;
  localparam int KX = 5, KY = 4, QW = 3, CW = 4;
  localparam int XW = $clog2(KX), YW = $clog2(KY);

  logic clk = 0, rst_n = 0;
  logic [XW-1:0] cur_x = '0, dst_x = '0;
  logic [YW-1:0] cur_y = '0, dst_y = '0;
  logic [QW-1:0] q_xp = '0, q_xn = '0, q_yp = '0, q_yn = '0;
  logic recover = 0, ckpt_tick = 0;
  logic [CW-1:0] reenable_cnt = '0;
  logic [3:0] port_sel;
  logic eject, adaptive_on;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  torus_route_sel #(.KX(KX), .KY(KY), .QW(QW), .CW(CW)) i_torus_route_sel (
    .clk(clk), .rst_n(rst_n), .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .q_xp(q_xp), .q_xn(q_xn), .q_yp(q_yp), .q_yn(q_yn), .recover(recover),
    .ckpt_tick(ckpt_tick), .reenable_cnt(reenable_cnt), .port_sel(port_sel),
    .eject(eject), .adaptive_on(adaptive_on));

  function automatic logic [4:0] exp_route(int cx, int cy, int tx, int ty,
                                           int a, int b, int c, int d, bit adapt);
    int ex, ey;
    logic [3:0] xp, yp;
    int qa, qb;
    ex = (tx - cx + KX) % KX;
    ey = (ty - cy + KY) % KY;
    xp = (2 * ex <= KX) ? 4'b0001 : 4'b0010;
    yp = (2 * ey <= KY) ? 4'b0100 : 4'b1000;
    qa = (2 * ex <= KX) ? a : b;
    qb = (2 * ey <= KY) ? c : d;
    if (ex == 0 && ey == 0) return 5'b10000;
    if (ex == 0) return {1'b0, yp};
    if (ey == 0 || !adapt) return {1'b0, xp};
    return (qa <= qb) ? {1'b0, xp} : {1'b0, yp};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic route(int cx, int cy, int tx, int ty, int a, int b, int c, int d,
                       bit adapt, string req);
    @(negedge clk);
    cur_x = XW'(cx); cur_y = YW'(cy); dst_x = XW'(tx); dst_y = YW'(ty);
    q_xp = QW'(a); q_xn = QW'(b); q_yp = QW'(c); q_yn = QW'(d);
    #1;
    check(req, {eject, port_sel}, exp_route(cx, cy, tx, ty, a, b, c, d, adapt));
  endtask

  task automatic ctl(bit r, bit t, int n);
    @(negedge clk);
    recover = r; ckpt_tick = t; reenable_cnt = CW'(n);
    @(negedge clk);
    recover = 0; ckpt_tick = 0;
    #1;
  endtask

  task automatic mode_chk(string req, bit exp);
    check(req, {4'b0, adaptive_on}, {4'b0, exp});
  endtask

  task automatic rand_routes(int n, bit adapt);
    for (int i = 0; i < n; i++) begin
      int cx, cy, tx, ty;
      cx = int'($urandom % KX); cy = int'($urandom % KY);
      tx = ($urandom % 4 == 0) ? cx : int'($urandom % KX);
      ty = ($urandom % 4 == 0) ? cy : int'($urandom % KY);
      route(cx, cy, tx, ty, int'($urandom % 8), int'($urandom % 8),
            int'($urandom % 8), int'($urandom % 8), adapt,
            adapt ? "R5/R6/R3 random adaptive" : "R4/R3 random static");
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    mode_chk("R7 reset adaptive", 1'b1);
    route(2, 1, 2, 1, 7, 7, 7, 7, 1, "R1 eject home");
    route(0, 0, 0, 2, 0, 0, 5, 0, 1, "R3 tie K/2 goes Y+");
    route(0, 0, 3, 0, 0, 0, 0, 0, 1, "R3 wrap to X-");
    route(0, 0, 1, 1, 4, 0, 4, 0, 1, "R5 queue tie to X");
    route(0, 0, 1, 1, 5, 0, 2, 0, 1, "R5 shorter Y queue");
    route(0, 0, 0, 3, 0, 0, 0, 7, 1, "R6 only Y productive");
    rand_routes(300, 1);
    ctl(1, 0, 0);
    mode_chk("R8 recover disables", 1'b0);
    route(0, 0, 1, 1, 5, 0, 0, 0, 0, "R4 static X first");
    rand_routes(200, 0);
    for (int i = 0; i < 4; i++) begin
      ctl(0, 1, 0);
      mode_chk("R10 zero count stays off", 1'b0);
    end
    ctl(0, 1, 3); mode_chk("R9 tick1 of 3", 1'b0);
    ctl(0, 1, 3); mode_chk("R9 tick2 of 3", 1'b0);
    ctl(1, 0, 3); mode_chk("R9 recover restarts", 1'b0);
    ctl(0, 1, 3); mode_chk("R9 restart tick1", 1'b0);
    ctl(0, 1, 3); mode_chk("R9 restart tick2", 1'b0);
    ctl(0, 1, 3); mode_chk("R9 third tick enables", 1'b1);
    route(0, 0, 1, 1, 5, 0, 2, 0, 1, "R5 after re-enable");
    ctl(1, 1, 1); mode_chk("R11 recover beats tick", 1'b0);
    ctl(0, 1, 1); mode_chk("R9 count one enables", 1'b1);
    rand_routes(100, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule